// File: doc/BRIEF.md
# I2C Master Bit-Level Waveform Sequencer

This block turns single bit-level commands into the SCL and SDA waveforms of an I2C master. A controller above it handles bytes, addresses and acknowledge policy. It hands over one command at a time: start, repeated start, write bit, read bit or stop. Each command uses a valid/ready handshake. The block answers every command with a one-clock completion pulse, and for a read bit it also returns the level it sampled on SDA.

Both bus lines are open-drain. The block never drives a line high. It only asserts a pull-low enable per line, and it reads the SDA pin back through an input. Every phase of the waveform has its own length in system clocks. All phase lengths are multiplied by a scale factor of (rate_div + 1), and the factor is captured when a command is accepted. The SDA change inside each bit does not happen at the SCL falling edge. It is placed partway into the SCL low period, so the previous level is held for a while and the new one is set up ahead of the rising edge.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both pull-low enables are 0, cmd_ready is 1 and done is 0.
- R2: Start (cmd_op 0), from an idle bus, pulls SDA low while SCL stays released for 6*k clocks. SCL is then pulled low as the command completes. Here k = rate_div + 1.
- R3: Repeated start, write, read and stop (cmd_op 1, 2, 3, 4) begin with SCL pulled low for 10*k clocks. For the first 7*k of those clocks SDA keeps its previous drive. It takes the command's new drive for the remaining 3*k.
- R4: After the low period, write, read and stop release SCL for 10*k clocks. Write and read then pull SCL low again as the command completes.
- R5: Repeated start releases SDA at the data point and releases SCL for 20*k clocks. It then pulls SDA low for 6*k clocks with SCL still released, and ends by pulling SCL low.
- R6: Stop pulls SDA low at the data point. After the 10*k-clock SCL high period it releases SDA, which leaves both lines released.
- R7: A read bit keeps SDA released from the data point to the end of the bit. It returns on rd_bit the level sda_i had on the last clock of the SCL high period, valid together with done.
- R8: cmd_ready is high only while idle, and a command offered while busy has no effect on the waveform. done is a single-clock pulse in the first idle cycle after a command.
- R9: All phase lengths, including the data point, scale with k for every rate_div value.
- R10: rate_div is captured at acceptance, and changing it during a command does not alter that command's timing.
- R11: For a write bit, cmd_bit 1 leaves SDA released and cmd_bit 0 pulls it low. SDA stays constant while SCL is released.
- R12: Opcodes 5 to 7 are accepted and produce done on the next clock without changing either line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all phase counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_div | input | DIV_W | Phase scale minus one, captured per command |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | Idle and able to accept a command |
| cmd_op | input | 3 | 0 start, 1 repeated start, 2 write bit, 3 read bit, 4 stop |
| cmd_bit | input | 1 | Data bit for a write command |
| done | output | 1 | One-clock completion pulse |
| rd_bit | output | 1 | Level sampled by the last read command |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Level present on the SDA line |

## Verification
The read sample point is the hardest case to reach from the ports. A design that samples one clock early or late returns the right value whenever the slave holds SDA steady. The bench therefore models the line as a wired-AND of the block's pull-low and a slave pull-low. It counts clocks inside the high phase and flips the slave's level on exactly the final clock, so only a sample on that clock returns the expected bit. The same cycle-exact loop also offers a second command and alters rate_div during the first phase of each command. This shows that neither disturbs the waveform, at every scale value in the sweep.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  localparam logic [2:0] OP_START  = 3'd0;
  localparam logic [2:0] OP_RSTART = 3'd1;
  localparam logic [2:0] OP_WRITE  = 3'd2;
  localparam logic [2:0] OP_READ   = 3'd3;
  localparam logic [2:0] OP_STOP   = 3'd4;

  // base phase lengths at scale 1
  localparam int unsigned BASE_W       = 5;
  localparam int unsigned BASE_HOLD    = 6;
  localparam int unsigned BASE_DHOLD   = 7;
  localparam int unsigned BASE_SETUP   = 3;
  localparam int unsigned BASE_HIGH    = 10;
  localparam int unsigned BASE_RS_HIGH = 20;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HOLD,
    PH_LOW1,
    PH_LOW2,
    PH_HIGH
  } phase_e;

endpackage

// File: rtl/i2c_phase_len.sv
module i2c_phase_len
  import i2c_bit_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned LEN_W = DIV_W + BASE_W
) (
  input  phase_e             phase,
  input  logic [2:0]         op,
  input  logic [DIV_W-1:0]   div,
  output logic [LEN_W-1:0]   len
);

  logic [BASE_W-1:0] base;

  always_comb begin
    case (phase)
      PH_HOLD: base = BASE_W'(BASE_HOLD);
      PH_LOW1: base = BASE_W'(BASE_DHOLD);
      PH_LOW2: base = BASE_W'(BASE_SETUP);
      PH_HIGH: base = (op == OP_RSTART) ? BASE_W'(BASE_RS_HIGH) : BASE_W'(BASE_HIGH);
      default: base = '0;
    endcase
  end

  always_comb begin
    len = LEN_W'(base) * (LEN_W'(div) + LEN_W'(1));
  end

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val - W'(1);
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             done,
  output logic             rd_bit,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);

  localparam int unsigned LEN_W = DIV_W + BASE_W;

  phase_e            phase_q, phase_d;
  logic [2:0]        op_q, op_d;
  logic              bit_q, bit_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              scl_q, scl_d;
  logic              sda_q, sda_d;
  logic              done_q, done_d;
  logic              rd_q, rd_d;
  logic              accept;
  logic              load;
  logic              last;
  logic              new_sda;
  logic [LEN_W-1:0]  len;

  // drive level SDA takes at the data point of the current command
  always_comb begin
    case (op_q)
      OP_WRITE: new_sda = !bit_q;
      OP_STOP:  new_sda = 1'b1;
      default:  new_sda = 1'b0;
    endcase
  end

  assign accept = cmd_valid && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    op_d    = op_q;
    bit_d   = bit_q;
    div_d   = div_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    load    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (cmd_valid) begin
          op_d  = cmd_op;
          bit_d = cmd_bit;
          div_d = rate_div;
          case (cmd_op)
            OP_START: begin
              phase_d = PH_HOLD;
              sda_d   = 1'b1;
              scl_d   = 1'b0;
              load    = 1'b1;
            end
            OP_RSTART, OP_WRITE, OP_READ, OP_STOP: begin
              phase_d = PH_LOW1;
              scl_d   = 1'b1;
              load    = 1'b1;
            end
            default: done_d = 1'b1;
          endcase
        end
      end
      PH_HOLD: begin
        if (last) begin
          phase_d = PH_IDLE;
          scl_d   = 1'b1;
          done_d  = 1'b1;
        end
      end
      PH_LOW1: begin
        if (last) begin
          phase_d = PH_LOW2;
          sda_d   = new_sda;
          load    = 1'b1;
        end
      end
      PH_LOW2: begin
        if (last) begin
          phase_d = PH_HIGH;
          scl_d   = 1'b0;
          load    = 1'b1;
        end
      end
      PH_HIGH: begin
        if (last) begin
          case (op_q)
            OP_RSTART: begin
              phase_d = PH_HOLD;
              sda_d   = 1'b1;
              load    = 1'b1;
            end
            OP_STOP: begin
              phase_d = PH_IDLE;
              sda_d   = 1'b0;
              done_d  = 1'b1;
            end
            default: begin
              phase_d = PH_IDLE;
              scl_d   = 1'b1;
              rd_d    = (op_q == OP_READ) ? sda_i : rd_q;
              done_d  = 1'b1;
            end
          endcase
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  i2c_phase_len #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_len (
    .phase (phase_d),
    .op    (op_d),
    .div   (div_d),
    .len   (len)
  );

  i2c_phase_timer #(.W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (len),
    .last     (last)
  );

  // command capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_START;
      bit_q <= 1'b0;
      div_q <= '0;
    end else if (accept) begin
      op_q  <= op_d;
      bit_q <= bit_d;
      div_q <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
      rd_q    <= rd_d;
    end
  end

  assign cmd_ready = (phase_q == PH_IDLE);
  assign done      = done_q;
  assign rd_bit    = rd_q;
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;

endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk
  import i2c_bit_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe
);

  logic [2:0] seen_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen_op <= 3'd7;
    else if (cmd_valid && cmd_ready) seen_op <= cmd_op;
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op <= OP_STOP) |=> !cmd_ready);

  p_start_sda_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_oe) && seen_op == OP_START) |-> sda_oe);

  p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && seen_op == OP_STOP) |-> !scl_oe);

  p_data_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && (seen_op == OP_WRITE || seen_op == OP_READ)
     && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && seen_op == OP_READ && !scl_oe) |-> !sda_oe);

endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .done      (done),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe)
);

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;
  import i2c_bit_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 2;

  logic             clk;
  logic             rst_n;
  logic [DIV_W-1:0] rate_div;
  logic             cmd_valid;
  logic             cmd_ready;
  logic [2:0]       cmd_op;
  logic             cmd_bit;
  logic             done;
  logic             rd_bit;
  logic             scl_oe;
  logic             sda_oe;
  logic             sda_i;
  logic             slave_low;

  int n_checks;
  int n_fail;
  bit finished;
  bit hook_pending;
  bit junk_en;
  logic [DIV_W-1:0] cur_div;
  logic e_sda;

  assign sda_i = !(sda_oe || slave_low);

  i2c_bit_engine #(.DIV_W(DIV_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_div  (rate_div),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_bit   (cmd_bit),
    .done      (done),
    .rd_bit    (rd_bit),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .sda_i     (sda_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = !clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // runs one phase of len cycles, comparing every cycle against the model
  task automatic run_phase(input int len, input bit e_scl, input bit e_sd,
                           input string req, input bit rd_ph, input bit rd_final);
    int bad;
    int act;
    bad = 0;
    act = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (hook_pending) begin
        hook_pending = 1'b0;
        rate_div = ~cur_div;
        if (junk_en) cmd_op = OP_STOP;
        else         cmd_valid = 1'b0;
      end
      if (rd_ph) slave_low = (i == len - 1) ? !rd_final : rd_final;
      if (scl_oe !== e_scl || sda_oe !== e_sd || cmd_ready !== 1'b0) begin
        if (bad == 0) act = {scl_oe, sda_oe, cmd_ready};
        bad++;
      end
    end
    check(bad == 0, req, act, {e_scl, e_sd, 1'b0});
  endtask

  task automatic run_cmd(input logic [2:0] op, input bit b, input bit rd_final, input bit junk);
    int k;
    bit nsd;
    k = int'(cur_div) + 1;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_bit   = b;
    rate_div  = cur_div;
    junk_en   = junk;
    hook_pending = 1'b1;
    @(posedge clk);
    if (op == OP_START) begin
      run_phase(6*k, 1'b0, 1'b1, "R2 start hold", 1'b0, 1'b0);
      e_sda = 1'b1;
    end else begin
      nsd = (op == OP_WRITE) ? !b : (op == OP_STOP);
      run_phase(7*k, 1'b1, e_sda, "R3 data hold", 1'b0, 1'b0);
      cmd_valid = 1'b0;
      run_phase(3*k, 1'b1, nsd, "R3 data setup", 1'b0, 1'b0);
      if (op == OP_RSTART) begin
        run_phase(20*k, 1'b0, 1'b0, "R5 rstart high", 1'b0, 1'b0);
        run_phase(6*k, 1'b0, 1'b1, "R5 rstart hold", 1'b0, 1'b0);
        e_sda = 1'b1;
      end else begin
        run_phase(10*k, 1'b0, nsd, (op == OP_READ) ? "R7 read high" : "R4 scl high",
                  op == OP_READ, rd_final);
        e_sda = (op == OP_STOP) ? 1'b0 : nsd;
      end
    end
    @(negedge clk);
    slave_low = 1'b0;
    rate_div  = cur_div;
    check(done === 1'b1 && cmd_ready === 1'b1, "R8 done with ready", {done, cmd_ready}, 3);
    if (op == OP_STOP)
      check(scl_oe === 1'b0 && sda_oe === 1'b0, "R6 bus released", {scl_oe, sda_oe}, 0);
    else
      check(scl_oe === 1'b1 && sda_oe === e_sda, "R4 scl low at end", {scl_oe, sda_oe}, {1'b1, e_sda});
    if (op == OP_READ)
      check(rd_bit === rd_final, "R7 read sample", rd_bit, rd_final);
    @(negedge clk);
    check(done === 1'b0, "R8 done single cycle", done, 0);
  endtask

  task automatic run_bad_op(input logic [2:0] op);
    logic s0;
    logic d0;
    @(negedge clk);
    s0 = scl_oe;
    d0 = sda_oe;
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done === 1'b1 && scl_oe === s0 && sda_oe === d0, "R12 unused opcode",
          {done, scl_oe, sda_oe}, {1'b1, s0, d0});
    @(negedge clk);
    check(done === 1'b0 && cmd_ready === 1'b1, "R12 back to idle", {done, cmd_ready}, 1);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    finished = 1'b0;
    hook_pending = 1'b0;
    junk_en = 1'b0;
    rst_n = 1'b0;
    rate_div = '0;
    cmd_valid = 1'b0;
    cmd_op = OP_START;
    cmd_bit = 1'b0;
    slave_low = 1'b0;
    cur_div = '0;
    e_sda = 1'b0;
    repeat (3) @(negedge clk);
    check(scl_oe === 1'b0 && sda_oe === 1'b0 && cmd_ready === 1'b1 && done === 1'b0,
          "R1 reset state", {scl_oe, sda_oe, cmd_ready, done}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_oe === 1'b0 && sda_oe === 1'b0 && cmd_ready === 1'b1, "R1 idle after reset",
          {scl_oe, sda_oe, cmd_ready}, 1);
    // R9 / R10: sweep every scale; rate_div is disturbed inside each command
    for (int d = 0; d < (1 << DIV_W); d++) begin
      cur_div = DIV_W'(d);
      run_cmd(OP_START,  1'b0, 1'b0, 1'b0);
      run_cmd(OP_WRITE,  1'b1, 1'b0, 1'b1);  // R11 bit 1 released, busy offer ignored
      run_cmd(OP_WRITE,  1'b0, 1'b0, 1'b0);  // R11 bit 0 pulled low
      run_cmd(OP_READ,   1'b0, 1'b1, 1'b1);
      run_cmd(OP_READ,   1'b0, 1'b0, 1'b0);
      run_cmd(OP_RSTART, 1'b0, 1'b0, 1'b1);
      run_cmd(OP_WRITE,  1'b0, 1'b0, 1'b0);
      run_bad_op(3'd5 + 3'(d % 3));
      run_cmd(OP_STOP,   1'b0, 1'b0, 1'b1);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule